// File: doc/BRIEF.md
# HDCP 2.2 Receiver Status Poller

This block fetches the two-byte receiver status word of an HDCP 2.2 sink through an external DDC engine and turns what it reads into maskable interrupt events. All of its timing is measured in horizontal-sync ticks from the video timing generator, so the polling rate and the timeouts follow the active video mode without reprogramming.

Software picks one of four poll modes through a small register port. In mode 0 polling is off. Mode 1 polls only while the authentication engine reports the link as authenticated. Mode 2 polls all the time. Mode 3 starts on a software trigger and keeps polling until the sink reports something software asked to hear about. The DDC engine is reached through a request/grant/done handshake. A request that waits too long for a grant raises an urgency flag, and a request that gets no answer in time is dropped and reported.

Top module: `rxs_poller`

## Requirements
- R1: After reset, registers 0 to 5 all read 0, and ddc_req_o, ddc_urgent_o and irq_o are 0.
- R2: With poll mode 0 (bits 1:0 of register 0) no request is raised, and a write to the trigger register (register 1) does not start one.
- R3: In mode 1 a request is raised only while auth_i is 1.
- R4: In mode 2 requests repeat whatever auth_i is. Let P be the request period in register 2 bits 15:0. Once an attempt ends, the next request rises in the cycle after the P-th hsync pulse. With P=0 it rises in the cycle after the attempt ends.
- R5: In mode 3 a write to register 1 arms polling, and reads then repeat at the request period. Polling stops after a completed read whose word meets one of the enabled conditions: nonzero size, ready, or reauth. No further request is raised until the next trigger.
- R6: The status word carries the message size in bits 9:0, ready in bit 10 and reauth in bit 11. A completed read updates register 4 as follows: the size goes into bits 29:20; bit 16 is set if ready is 1 and bit 15 if it is 0; bit 12 is set on reauth; bit 4 marks the read as done. Bit 0 is set each time a request is issued.
- R7: A read that ends with ddc_fail_i set sets bit 8 of register 4. It leaves the size field and bit 4 untouched and ends the attempt.
- R8: Let T be the timeout in register 3 bits 15:0. If no response arrives within T hsync pulses of the request, ddc_req_o is low in the cycle after the T-th pulse and bit 0 of register 5 is set. T=0 disables the timeout. Until a grant or a timeout, the request stays raised.
- R9: ddc_urgent_o is 1 while a request has waited for its grant for at least U hsync pulses, where U is register 3 bits 31:16 and is nonzero. The output is never 1 without a pending request.
- R10: The acknowledge bits read as 0: bits 1, 5, 9, 13, 17 and 30 of register 4, and bit 1 of register 5. Writing 1 to one of them clears its status, where bit 17 clears both 16 and 15 and bit 30 zeroes the size. irq_o is the OR of each status ANDed with its enable. The enables are bits 2, 6, 10 and 14; bit 18 for ready=1 and bit 19 for ready=0; bit 31 for a nonzero size; and bit 2 of register 5 for the timeout.
- R11: While bit 2 of register 0 is 1, every hsync counter is held at zero and no request is issued. Clearing the bit restarts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on the index) |
| hsync_i | input | 1 | One-cycle horizontal-sync tick |
| auth_i | input | 1 | Link authenticated |
| ddc_req_o | output | 1 | Status read request to the DDC engine |
| ddc_urgent_o | output | 1 | Pending request has waited past the urgent threshold |
| ddc_gnt_i | input | 1 | DDC engine accepted the request |
| ddc_done_i | input | 1 | DDC engine finished the read |
| ddc_fail_i | input | 1 | Qualifies ddc_done_i as a failed read |
| ddc_data_i | input | 16 | Status word returned with ddc_done_i |
| irq_o | output | 1 | Interrupt |

## Verification
Every count is made in whole hsync pulses. The bench drives each pulse as one cycle wide and samples on the falling edge, so each result's latency is fixed. A request rises one cycle after the pulse that fills the period. A timed-out request is low one cycle after the T-th pulse. The urgency flag is already up at the sample that directly follows the U-th pulse. Status fields can be read one cycle after ddc_done_i, and irq_o follows an acknowledge or enable write in the next cycle. The bench sweeps the period from 0 to 4 and the timeout/urgent pairs from (2,1) to (4,3). At each pulse it checks that the output is still inactive before the due cycle and active at it.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned SIZE_W = 10;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NEVT   = 4;   // req, done, fail, reauth triplets

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TRIG = 3'd1;
  localparam logic [2:0] A_PER  = 3'd2;
  localparam logic [2:0] A_TMO  = 3'd3;
  localparam logic [2:0] A_INT0 = 3'd4;
  localparam logic [2:0] A_INT1 = 3'd5;

  localparam logic [1:0] M_OFF   = 2'd0;
  localparam logic [1:0] M_AUTH  = 2'd1;
  localparam logic [1:0] M_FORCE = 2'd2;
  localparam logic [1:0] M_SW    = 2'd3;

  localparam int unsigned B_READY  = 10;
  localparam int unsigned B_REAUTH = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_BUSY} seq_st_e;
endpackage

// File: rtl/rxs_regs.sv
module rxs_regs
  import rxs_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [1:0]        mode_o,
  output logic              tmr_rst_o,
  output logic [TW-1:0]     period_o,
  output logic [TW-1:0]     tmo_lim_o,
  output logic [TW-1:0]     urg_lim_o,
  output logic              trig_o,
  output logic              size_en_o,
  output logic [1:0]        rdy_en_o,
  output logic              reauth_en_o,
  output logic              irq_o,
  input  logic              ev_req_i,
  input  logic              ev_done_i,
  input  logic              ev_fail_i,
  input  logic              ev_tmo_i,
  input  logic [WORD_W-1:0] word_i
);
  logic [1:0]        mode_q;
  logic              trst_q;
  logic [TW-1:0]     per_q, tmo_q, urg_q;
  logic              st_rdy_q, st_nrdy_q, st_tmo_q, en_tmo_q, en_size_q;
  logic [1:0]        en_rdy_q;
  logic [SIZE_W-1:0] size_q;
  logic [NEVT-1:0]   ev_set, st_vec, en_vec;
  logic              wr_int0, wr_int1;

  assign wr_int0 = we_i && (addr_i == A_INT0);
  assign wr_int1 = we_i && (addr_i == A_INT1);
  assign trig_o  = we_i && (addr_i == A_TRIG);
  assign ev_set  = {ev_done_i & word_i[B_REAUTH], ev_fail_i, ev_done_i, ev_req_i};

  // status / ack / enable triplets at bit 4g, 4g+1, 4g+2
  for (genvar g = 0; g < NEVT; g++) begin : g_evt
    logic st_q, en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= 1'b0;
        en_q <= 1'b0;
      end else begin
        st_q <= ev_set[g] | (st_q & ~(wr_int0 & wdata_i[4*g+1]));
        if (wr_int0) en_q <= wdata_i[4*g+2];
      end
    end
    assign st_vec[g] = st_q;
    assign en_vec[g] = en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_OFF;
      trst_q    <= 1'b0;
      per_q     <= '0;
      tmo_q     <= '0;
      urg_q     <= '0;
      st_rdy_q  <= 1'b0;
      st_nrdy_q <= 1'b0;
      st_tmo_q  <= 1'b0;
      en_tmo_q  <= 1'b0;
      en_size_q <= 1'b0;
      en_rdy_q  <= 2'b0;
      size_q    <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) begin
        mode_q <= wdata_i[1:0];
        trst_q <= wdata_i[2];
      end
      if (we_i && addr_i == A_PER) per_q <= wdata_i[TW-1:0];
      if (we_i && addr_i == A_TMO) begin
        tmo_q <= wdata_i[TW-1:0];
        urg_q <= wdata_i[16 +: TW];
      end
      if (wr_int0) begin
        en_rdy_q  <= wdata_i[19:18];
        en_size_q <= wdata_i[31];
      end
      if (wr_int1) en_tmo_q <= wdata_i[2];
      // a hardware event in the same cycle wins over the acknowledge
      st_rdy_q  <= (ev_done_i &  word_i[B_READY]) | (st_rdy_q  & ~(wr_int0 & wdata_i[17]));
      st_nrdy_q <= (ev_done_i & ~word_i[B_READY]) | (st_nrdy_q & ~(wr_int0 & wdata_i[17]));
      st_tmo_q  <= ev_tmo_i | (st_tmo_q & ~(wr_int1 & wdata_i[1]));
      if (ev_done_i)                    size_q <= word_i[SIZE_W-1:0];
      else if (wr_int0 && wdata_i[30])  size_q <= '0;
    end
  end

  assign mode_o      = mode_q;
  assign tmr_rst_o   = trst_q;
  assign period_o    = per_q;
  assign tmo_lim_o   = tmo_q;
  assign urg_lim_o   = urg_q;
  assign size_en_o   = en_size_q;
  assign rdy_en_o    = en_rdy_q;
  assign reauth_en_o = en_vec[3];

  assign irq_o = (|(st_vec & en_vec))
               | (en_size_q && size_q != '0)
               | (en_rdy_q[0] & st_rdy_q)
               | (en_rdy_q[1] & st_nrdy_q)
               | (en_tmo_q & st_tmo_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[2:0] = {trst_q, mode_q};
      A_PER:  rdata_o[TW-1:0] = per_q;
      A_TMO: begin
        rdata_o[TW-1:0]  = tmo_q;
        rdata_o[16 +: TW] = urg_q;
      end
      A_INT0: begin
        for (int g = 0; g < NEVT; g++) begin
          rdata_o[4*g]   = st_vec[g];
          rdata_o[4*g+2] = en_vec[g];
        end
        rdata_o[15]    = st_nrdy_q;
        rdata_o[16]    = st_rdy_q;
        rdata_o[19:18] = en_rdy_q;
        rdata_o[29:20] = size_q;
        rdata_o[31]    = en_size_q;
      end
      A_INT1: begin
        rdata_o[0] = st_tmo_q;
        rdata_o[2] = en_tmo_q;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rxs_seq.sv
module rxs_seq
  import rxs_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              auth_i,
  input  logic [1:0]        mode_i,
  input  logic              tmr_rst_i,
  input  logic [TW-1:0]     period_i,
  input  logic [TW-1:0]     tmo_lim_i,
  input  logic [TW-1:0]     urg_lim_i,
  input  logic              trig_i,
  input  logic              size_en_i,
  input  logic [1:0]        rdy_en_i,
  input  logic              reauth_en_i,
  input  logic              ddc_gnt_i,
  input  logic              ddc_done_i,
  input  logic              ddc_fail_i,
  input  logic [WORD_W-1:0] ddc_data_i,
  output logic              ddc_req_o,
  output logic              ddc_urgent_o,
  output logic              ev_req_o,
  output logic              ev_done_o,
  output logic              ev_fail_o,
  output logic              ev_tmo_o
);
  seq_st_e       st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          sw_act_q, active, issue, resp, stop_hit;

  always_comb begin
    unique case (mode_i)
      M_AUTH:  active = auth_i;
      M_FORCE: active = 1'b1;
      M_SW:    active = sw_act_q;
      default: active = 1'b0;
    endcase
  end

  assign issue     = (st_q == ST_IDLE) && active && !tmr_rst_i && (cnt_q >= period_i);
  assign resp      = (st_q == ST_BUSY) && ddc_done_i;
  assign ev_req_o  = issue;
  assign ev_done_o = resp & ~ddc_fail_i;
  assign ev_fail_o = resp &  ddc_fail_i;
  assign ev_tmo_o  = (st_q != ST_IDLE) && !resp && (tmo_lim_i != '0) && (cnt_q >= tmo_lim_i);

  assign stop_hit = ev_done_o &&
                    ((size_en_i && ddc_data_i[SIZE_W-1:0] != '0) ||
                     (rdy_en_i[0] &&  ddc_data_i[B_READY]) ||
                     (rdy_en_i[1] && !ddc_data_i[B_READY]) ||
                     (reauth_en_i &&  ddc_data_i[B_REAUTH]));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (issue) st_d = ST_REQ;
      ST_REQ: begin
        if (ev_tmo_o)       st_d = ST_IDLE;
        else if (ddc_gnt_i) st_d = ST_BUSY;
      end
      ST_BUSY: if (resp || ev_tmo_o) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    // one counter: idle period, then grant/response wait since the request
    if (tmr_rst_i || issue || (st_q != ST_IDLE && st_d == ST_IDLE)) begin
      cnt_d = '0;
    end else if (hsync_i) begin
      if (st_q == ST_IDLE) begin
        if (cnt_q < period_i) cnt_d = cnt_q + 1'b1;
      end else if (cnt_q != '1) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sw_act_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (mode_i != M_SW) sw_act_q <= 1'b0;
      else if (trig_i)    sw_act_q <= 1'b1;
      else if (stop_hit)  sw_act_q <= 1'b0;
    end
  end

  assign ddc_req_o    = (st_q == ST_REQ);
  assign ddc_urgent_o = (st_q == ST_REQ) && (urg_lim_i != '0) && (cnt_q >= urg_lim_i);
endmodule

// File: rtl/rxs_poller.sv
module rxs_poller
  import rxs_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        hsync_i,
  input  logic        auth_i,
  output logic        ddc_req_o,
  output logic        ddc_urgent_o,
  input  logic        ddc_gnt_i,
  input  logic        ddc_done_i,
  input  logic        ddc_fail_i,
  input  logic [15:0] ddc_data_i,
  output logic        irq_o
);
  logic [1:0]    mode, rdy_en;
  logic          tmr_rst, trig, size_en, reauth_en;
  logic [TW-1:0] period, tmo_lim, urg_lim;
  logic          ev_req, ev_done, ev_fail, ev_tmo;

  rxs_regs #(.TW(TW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .mode_o      (mode),
    .tmr_rst_o   (tmr_rst),
    .period_o    (period),
    .tmo_lim_o   (tmo_lim),
    .urg_lim_o   (urg_lim),
    .trig_o      (trig),
    .size_en_o   (size_en),
    .rdy_en_o    (rdy_en),
    .reauth_en_o (reauth_en),
    .irq_o       (irq_o),
    .ev_req_i    (ev_req),
    .ev_done_i   (ev_done),
    .ev_fail_i   (ev_fail),
    .ev_tmo_i    (ev_tmo),
    .word_i      (ddc_data_i)
  );

  rxs_seq #(.TW(TW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hsync_i      (hsync_i),
    .auth_i       (auth_i),
    .mode_i       (mode),
    .tmr_rst_i    (tmr_rst),
    .period_i     (period),
    .tmo_lim_i    (tmo_lim),
    .urg_lim_i    (urg_lim),
    .trig_i       (trig),
    .size_en_i    (size_en),
    .rdy_en_i     (rdy_en),
    .reauth_en_i  (reauth_en),
    .ddc_gnt_i    (ddc_gnt_i),
    .ddc_done_i   (ddc_done_i),
    .ddc_fail_i   (ddc_fail_i),
    .ddc_data_i   (ddc_data_i),
    .ddc_req_o    (ddc_req_o),
    .ddc_urgent_o (ddc_urgent_o),
    .ev_req_o     (ev_req),
    .ev_done_o    (ev_done),
    .ev_fail_o    (ev_fail),
    .ev_tmo_o     (ev_tmo)
  );
endmodule

// File: rtl/rxs_poller_chk.sv
module rxs_poller_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       tmr_rst_i,
  input logic       auth_i,
  input logic       ddc_req_i,
  input logic       ddc_gnt_i,
  input logic       ddc_urgent_i,
  input logic       ev_tmo_i
);
  AST_OFF_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !ddc_req_i) |=> !ddc_req_i); // R2

  AST_UNAUTH_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !auth_i && !ddc_req_i) |=> !ddc_req_i); // R3

  AST_TMO_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_tmo_i |=> !ddc_req_i); // R8

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ddc_req_i && !ddc_gnt_i && !ev_tmo_i) |=> ddc_req_i); // R8

  AST_URGENT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ddc_urgent_i |-> ddc_req_i); // R9

  AST_TRST_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_rst_i && !ddc_req_i) |=> !ddc_req_i); // R11
endmodule

bind rxs_poller rxs_poller_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode),
  .tmr_rst_i    (tmr_rst),
  .auth_i       (auth_i),
  .ddc_req_i    (ddc_req_o),
  .ddc_gnt_i    (ddc_gnt_i),
  .ddc_urgent_i (ddc_urgent_o),
  .ev_tmo_i     (ev_tmo)
);

// File: tb/tb_rxs_poller.sv
module tb_rxs_poller;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        hsync_i = 1'b0;
  logic        auth_i = 1'b0;
  logic        ddc_req_o, ddc_urgent_o, irq_o;
  logic        ddc_gnt_i = 1'b0;
  logic        ddc_done_i = 1'b0;
  logic        ddc_fail_i = 1'b0;
  logic [15:0] ddc_data_i = '0;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  localparam logic [31:0] ACK_ALL = 32'h4002_2222;

  always #2.5 clk_i = ~clk_i;

  rxs_poller dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr_i = a;
    #0.5;
    v = reg_rdata_o;
  endtask

  task automatic pulse_hs();
    hsync_i = 1'b1;
    @(negedge clk_i);
    hsync_i = 1'b0;
  endtask

  task automatic wait_req(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (ddc_req_o) begin seen = 1'b1; break; end
      pulse_hs();
      cyc(1);
    end
    chk(seen, tag, {31'b0, ddc_req_o}, 32'h1);
  endtask

  task automatic serve(input logic [15:0] w, input bit fail);
    ddc_gnt_i = 1'b1;
    @(negedge clk_i);
    ddc_gnt_i = 1'b0; ddc_done_i = 1'b1; ddc_fail_i = fail; ddc_data_i = w;
    @(negedge clk_i);
    ddc_done_i = 1'b0; ddc_fail_i = 1'b0;
  endtask

  task automatic hold_quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      pulse_hs();
      cyc(1);
      chk(ddc_req_o == 1'b0, tag, {31'b0, ddc_req_o}, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v);
      chk(v == 32'h0, "R1 reg reset", v, 32'h0);
    end
    chk({ddc_req_o, ddc_urgent_o, irq_o} == 3'b0, "R1 outputs reset",
        {29'b0, ddc_req_o, ddc_urgent_o, irq_o}, 32'h0);

    // R2 mode 0 ignores hsync and trigger
    wr(3'd2, 32'd1);
    hold_quiet(4, "R2 mode0 quiet");
    wr(3'd1, 32'd1);
    hold_quiet(3, "R2 trigger ignored");

    // R4 pacing sweep, timeout off
    for (int p = 0; p <= 4; p++) begin
      wr(3'd0, 32'd0);
      wr(3'd2, p);
      wr(3'd0, 32'd2);
      wait_req("R4 first request");
      serve(16'h0000, 1'b0);
      for (int k = 1; k <= p; k++) begin
        chk(ddc_req_o == 1'b0, "R4 early", {31'b0, ddc_req_o}, 32'h0);
        pulse_hs();
      end
      cyc(1);
      chk(ddc_req_o == 1'b1, "R4 due", {31'b0, ddc_req_o}, 32'h1);
      if (p == 4) begin
        hold_quiet(0, "");
        for (int k = 0; k < 6; k++) pulse_hs();
        chk(ddc_req_o == 1'b1, "R8 timeout 0 disables", {31'b0, ddc_req_o}, 32'h1);
      end
      wr(3'd0, 32'd0);
      serve(16'h0000, 1'b0);
      wr(3'd4, ACK_ALL);
    end

    // R6 capture sweep and R10 ack
    wr(3'd2, 32'd1);
    wr(3'd0, 32'd2);
    for (int i = 0; i < 8; i++) begin
      logic [9:0] sz;
      logic [15:0] w;
      sz = 10'((i * 149) & 10'h3ff);
      w  = {4'b0, i[2], i[1], sz};
      wait_req("R6 request");
      serve(w, 1'b0);
      rd(3'd4, v);
      e = 32'h11 | (32'(sz) << 20) | (i[1] ? 32'h1_0000 : 32'h8000) | (i[2] ? 32'h1000 : 32'h0);
      chk(v == e, "R6 capture", v, e);
      wr(3'd4, ACK_ALL);
      rd(3'd4, v);
      chk(v == 32'h0, "R10 ack clears", v, 32'h0);
    end

    // R10 enables gate irq
    wr(3'd4, 32'h8000_0000);
    wait_req("R10 request");
    serve(16'h0005, 1'b0);
    chk(irq_o == 1'b1, "R10 size irq", {31'b0, irq_o}, 32'h1);
    wr(3'd4, 32'hC000_0000);
    chk(irq_o == 1'b0, "R10 size ack", {31'b0, irq_o}, 32'h0);
    wr(3'd4, 32'h0000_0040);
    chk(irq_o == 1'b1, "R10 done enable", {31'b0, irq_o}, 32'h1);
    wr(3'd4, ACK_ALL);
    chk(irq_o == 1'b0, "R10 all acked", {31'b0, irq_o}, 32'h0);
    wait_req("R10 request 2");
    serve(16'h0000, 1'b0);
    wr(3'd4, 32'h0004_0000);
    chk(irq_o == 1'b0, "R10 ready=1 enable quiet", {31'b0, irq_o}, 32'h0);
    wr(3'd4, 32'h0008_0000);
    chk(irq_o == 1'b1, "R10 ready=0 enable", {31'b0, irq_o}, 32'h1);
    wr(3'd4, ACK_ALL);

    // R7 failed read
    wait_req("R7 request");
    serve(16'h03ff, 1'b1);
    rd(3'd4, v);
    chk(v == 32'h101, "R7 fail flags", v, 32'h101);
    cyc(1);
    chk(ddc_req_o == 1'b0, "R7 attempt ended", {31'b0, ddc_req_o}, 32'h0);
    wr(3'd4, ACK_ALL);

    // R8 / R9 timeout and urgent sweep
    for (int t = 2; t <= 4; t++) begin
      int u;
      u = t - 1;
      wr(3'd3, (u << 16) | t);
      wait_req("R8 request");
      for (int k = 1; k <= t; k++) begin
        pulse_hs();
        if (k < t) begin
          chk(ddc_req_o == 1'b1, "R8 still pending", {31'b0, ddc_req_o}, 32'h1);
          chk(ddc_urgent_o == (k >= u), "R9 urgent", {31'b0, ddc_urgent_o}, {31'b0, k >= u});
        end
      end
      cyc(1);
      chk(ddc_req_o == 1'b0, "R8 dropped", {31'b0, ddc_req_o}, 32'h0);
      chk(ddc_urgent_o == 1'b0, "R9 urgent clear", {31'b0, ddc_urgent_o}, 32'h0);
      rd(3'd5, v);
      chk(v == 32'h1, "R8 timeout status", v, 32'h1);
      wr(3'd5, 32'h4);
      chk(irq_o == 1'b1, "R10 timeout irq", {31'b0, irq_o}, 32'h1);
      wr(3'd5, 32'h2);
      rd(3'd5, v);
      chk(v == 32'h0, "R10 timeout ack", v, 32'h0);
    end
    wr(3'd3, 32'h0);
    wr(3'd0, 32'd0);
    wr(3'd4, ACK_ALL);

    // R3 mode 1
    wr(3'd0, 32'd1);
    hold_quiet(4, "R3 unauth quiet");
    auth_i = 1'b1;
    wait_req("R3 auth request");
    serve(16'h0000, 1'b0);
    auth_i = 1'b0;
    hold_quiet(4, "R3 auth dropped");
    wr(3'd0, 32'd0);

    // R5 mode 3
    wr(3'd4, 32'h0000_4000 | ACK_ALL);
    wr(3'd0, 32'd3);
    hold_quiet(3, "R5 untriggered");
    wr(3'd1, 32'd1);
    wait_req("R5 triggered");
    serve(16'h0400, 1'b0);
    wait_req("R5 repeats");
    serve(16'h0800, 1'b0);
    chk(irq_o == 1'b1, "R5 reauth irq", {31'b0, irq_o}, 32'h1);
    hold_quiet(5, "R5 stopped");
    wr(3'd1, 32'd1);
    wait_req("R5 retrigger");
    serve(16'h0800, 1'b0);
    hold_quiet(2, "R5 stopped again");
    wr(3'd0, 32'd0);
    wr(3'd4, ACK_ALL);

    // R11 timer reset
    wr(3'd0, 32'd6);
    hold_quiet(5, "R11 held");
    wr(3'd0, 32'd2);
    cyc(1);
    chk(ddc_req_o == 1'b0, "R11 restart from zero", {31'b0, ddc_req_o}, 32'h0);
    pulse_hs();
    cyc(1);
    chk(ddc_req_o == 1'b1, "R11 counting resumed", {31'b0, ddc_req_o}, 32'h1);
    wr(3'd0, 32'd0);
    serve(16'h0000, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule